// File: doc/BRIEF.md
# Eight-Bank Interleaved Read Command Pattern Generator

This block drives the command stream for an interleaved read stress pattern on an eight-bank DDR2 memory. Each pass walks the banks in ascending order. Every bank gets an activate, and the very next slot is a read with auto-precharge. Between the pairs the block inserts deselect slots. Their number is fixed by a two-bit speed-grade select. The pattern therefore meets the activate-to-activate spacing and the four-activate window of that grade without a general timing scheduler. Each read uses a burst of four and closes its own row, so the block never issues a precharge.

The block issues one slot per enabled clock, and every output is registered. During a deselect slot, chip select goes high and all the other control and address outputs keep their previous levels. A one-clock wrap strobe marks the final slot of a pass, and the next pass starts at bank 0 without an idle slot. The grade select only takes effect at the start of a pass. Clearing the enable freezes the sequence and emits deselects until the enable returns.

Top module: `ilv_cmd_gen`

## Requirements
- R1: While reset is asserted and until the first enabled edge, the outputs are a deselect (cmdCode 0), ctrlN 4'b1111, bankAddr 0, addrBus 0 and wrapOut 0.
- R2: Command codes and active-low control bits {CS#,RAS#,CAS#,WE#}: activate is cmdCode 1 with ctrlN 4'b0011; read with auto-precharge is cmdCode 2 with ctrlN 4'b0101 and addrBus bit 10 high; deselect is cmdCode 0 with ctrlN bit 3 high.
- R3: Within a pass, banks 0 to 7 are served in ascending order. Each activate is followed in the next enabled slot by a read to the same bank.
- R4: Grade 0 (400): a pass is 16 slots of activate/read pairs with no deselect.
- R5: Grade 1 (533): two deselects follow the reads to banks 3 and 7, with no other gaps; a pass is 20 slots.
- R6: Grade 2 (667): one deselect follows each read, and one more follows banks 3 and 7; a pass is 26 slots.
- R7: Grade 3 (800): one deselect follows each read, and two more follow banks 3 and 7; a pass is 28 slots.
- R8: During a deselect, bankAddr, addrBus and ctrlN bits 2..0 hold their values from the previous cycle.
- R9: wrapOut is high for exactly the final slot of each pass, and the next enabled slot is the activate to bank 0.
- R10: gradeSel is sampled only when the bank 0 activate is issued. A change in the middle of a pass alters nothing until the next pass.
- R11: While enable is low, the block emits deselects with wrapOut low and does not advance. When enable returns, the sequence resumes at the slot that was paused.
- R12: An activate drives addrBus = ROW_BASE + bank (default 0x0123 + bank). A read drives COL_BASE with bit 10 set (default 0x0440).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Advance the pattern by one slot per clock when high |
| gradeSel | input | 2 | Speed grade: 0=400, 1=533, 2=667, 3=800 |
| cmdCode | output | 2 | Slot command: 0 deselect, 1 activate, 2 read with auto-precharge |
| ctrlN | output | 4 | Active-low {CS#,RAS#,CAS#,WE#} |
| bankAddr | output | 3 | Bank address |
| addrBus | output | 14 | Row address on activate, column address with bit 10 on read |
| wrapOut | output | 1 | One-clock strobe on the last slot of a pass |

## Verification
The assertions check the relations that hold on every cycle. These are the control encodings of each command, the hold of address, bank and control levels during deselects, and the activate-then-same-bank-read order. They also check the step to the next bank or a gap after each read, the single-cycle wrap followed by a bank 0 activate, and the idle deselects while the enable is low. The exact gap count per grade, the pass lengths and the rule that a grade change waits for the next pass depend on the grade latched at the start of the pass. Only the bench's reference sequence can show these, under directed full passes, a change of grade in the middle of a pass, pauses, and random stimulus.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    CMD_DES = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RDA = 2'd2
  } cmd_e;

  // strobes from the sequencer to the command datapath
  typedef struct packed {
    logic doAct;
    logic doRda;
    logic doDes;
    logic wrap;
  } slotCtl_t;

  // deselect slots after a read, given the grade and whether the bank closes a group of four
  function automatic logic [1:0] gapFor(input logic [1:0] grade, input logic groupEnd);
    logic [1:0] base;
    logic [1:0] extra;
    base = (grade >= 2'd2) ? 2'd1 : 2'd0;
    case (grade)
      2'd0:    extra = 2'd0;
      2'd2:    extra = 2'd1;
      default: extra = 2'd2;
    endcase
    return groupEnd ? 2'(base + extra) : base;
  endfunction

endpackage

// File: rtl/ilv_seq_ctl.sv
module ilv_seq_ctl
  import ilv_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        gradeSel,
  output slotCtl_t          slotCtl,
  output logic [BANK_W-1:0] slotBank
);

  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);
  localparam logic [BANK_W-1:0] MID_BANK  = BANK_W'(NUM_BANKS / 2 - 1);

  typedef enum logic [1:0] {PH_ACT, PH_RDA, PH_GAP} phase_e;

  phase_e            phase, phaseNext;
  logic [BANK_W-1:0] bankCnt, bankNext;
  logic [1:0]        gapLeft, gapNext;
  logic [1:0]        activeGrade, gradeNext;
  logic [1:0]        gapsHere;
  logic              lastBank;

  assign lastBank = (bankCnt == LAST_BANK);
  assign gapsHere = gapFor(activeGrade, (bankCnt == MID_BANK) || lastBank);
  assign slotBank = bankCnt;

  always_comb begin
    phaseNext = phase;
    bankNext  = bankCnt;
    gapNext   = gapLeft;
    gradeNext = activeGrade;
    slotCtl   = '0;
    if (!enable) begin
      slotCtl.doDes = 1'b1;
    end else begin
      case (phase)
        PH_ACT: begin
          slotCtl.doAct = 1'b1;
          if (bankCnt == '0) gradeNext = gradeSel;
          phaseNext = PH_RDA;
        end
        PH_RDA: begin
          slotCtl.doRda = 1'b1;
          if (gapsHere == 2'd0) begin
            slotCtl.wrap = lastBank;
            phaseNext    = PH_ACT;
            bankNext     = lastBank ? '0 : bankCnt + 1'b1;
          end else begin
            phaseNext = PH_GAP;
            gapNext   = gapsHere;
          end
        end
        default: begin
          slotCtl.doDes = 1'b1;
          if (gapLeft == 2'd1) begin
            slotCtl.wrap = lastBank;
            phaseNext    = PH_ACT;
            bankNext     = lastBank ? '0 : bankCnt + 1'b1;
          end else begin
            gapNext = gapLeft - 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase       <= PH_ACT;
      bankCnt     <= '0;
      gapLeft     <= '0;
      activeGrade <= '0;
    end else begin
      phase       <= phaseNext;
      bankCnt     <= bankNext;
      gapLeft     <= gapNext;
      activeGrade <= gradeNext;
    end
  end

endmodule

// File: rtl/ilv_cmd_dp.sv
module ilv_cmd_dp
  import ilv_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W = 14,
  parameter int AP_BIT = 10,
  parameter logic [ADDR_W-1:0] ROW_BASE = 'h0123,
  parameter logic [ADDR_W-1:0] COL_BASE = 'h0040,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  slotCtl_t          slotCtl,
  input  logic [BANK_W-1:0] slotBank,
  output logic [1:0]        cmdCode,
  output logic [3:0]        ctrlN,
  output logic [BANK_W-1:0] bankAddr,
  output logic [ADDR_W-1:0] addrBus,
  output logic              wrapOut
);

  localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

  logic [ADDR_W-1:0] rowAddr;
  logic [ADDR_W-1:0] colAddr;

  assign rowAddr = ROW_BASE + {{(ADDR_W-BANK_W){1'b0}}, slotBank};
  assign colAddr = COL_BASE | AP_MASK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdCode  <= CMD_DES;
      ctrlN    <= 4'b1111;
      bankAddr <= '0;
      addrBus  <= '0;
      wrapOut  <= 1'b0;
    end else begin
      wrapOut <= slotCtl.wrap;
      if (slotCtl.doAct) begin
        cmdCode  <= CMD_ACT;
        ctrlN    <= 4'b0011;
        bankAddr <= slotBank;
        addrBus  <= rowAddr;
      end else if (slotCtl.doRda) begin
        cmdCode  <= CMD_RDA;
        ctrlN    <= 4'b0101;
        bankAddr <= slotBank;
        addrBus  <= colAddr;
      end else begin
        cmdCode  <= CMD_DES;
        ctrlN[3] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ilv_cmd_gen.sv
module ilv_cmd_gen
  import ilv_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W = 14,
  parameter int AP_BIT = 10,
  parameter logic [ADDR_W-1:0] ROW_BASE = 'h0123,
  parameter logic [ADDR_W-1:0] COL_BASE = 'h0040,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        gradeSel,
  output logic [1:0]        cmdCode,
  output logic [3:0]        ctrlN,
  output logic [BANK_W-1:0] bankAddr,
  output logic [ADDR_W-1:0] addrBus,
  output logic              wrapOut
);

  slotCtl_t          slotCtl;
  logic [BANK_W-1:0] slotBank;

  ilv_seq_ctl #(.NUM_BANKS(NUM_BANKS)) u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .gradeSel(gradeSel),
    .slotCtl(slotCtl), .slotBank(slotBank)
  );

  ilv_cmd_dp #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT),
    .ROW_BASE(ROW_BASE), .COL_BASE(COL_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .slotCtl(slotCtl), .slotBank(slotBank),
    .cmdCode(cmdCode), .ctrlN(ctrlN), .bankAddr(bankAddr),
    .addrBus(addrBus), .wrapOut(wrapOut)
  );

endmodule

// File: rtl/ilv_cmd_gen_chk.sv
module ilv_cmd_gen_chk #(
  parameter int BANK_W = 3,
  parameter int ADDR_W = 14,
  parameter int AP_BIT = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic [1:0]        cmdCode,
  input logic [3:0]        ctrlN,
  input logic [BANK_W-1:0] bankAddr,
  input logic [ADDR_W-1:0] addrBus,
  input logic              wrapOut
);

  // R2
  act_enc_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdCode == 2'd1 |-> ctrlN == 4'b0011);

  // R2
  rda_enc_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdCode == 2'd2 |-> ctrlN == 4'b0101 && addrBus[AP_BIT]);

  // R8
  des_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdCode == 2'd0 |-> ctrlN[3] && $stable(ctrlN[2:0]) && $stable(bankAddr) && $stable(addrBus));

  // R3
  act_then_rda_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdCode == 2'd1 && enable |=> cmdCode == 2'd2 && $stable(bankAddr));

  // R3
  rda_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdCode == 2'd2 && enable |=> cmdCode == 2'd0 ||
      (cmdCode == 2'd1 && bankAddr == BANK_W'($past(bankAddr) + 1'b1)));

  // R9
  wrap_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrapOut && enable |=> cmdCode == 2'd1 && bankAddr == '0);

  // R9
  wrap_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrapOut |=> !wrapOut);

  // R11
  idle_des_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> cmdCode == 2'd0 && !wrapOut);

endmodule

bind ilv_cmd_gen ilv_cmd_gen_chk #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .cmdCode(cmdCode), .ctrlN(ctrlN),
  .bankAddr(bankAddr), .addrBus(addrBus), .wrapOut(wrapOut)
);

// File: tb/ilv_cmd_gen_bench.sv
module ilv_cmd_gen_bench;

  localparam logic [13:0] ROWB  = 14'h0123;
  localparam logic [13:0] COLAP = 14'h0440;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  gradeSel = 2'd0;
  logic [1:0]  cmdCode;
  logic [3:0]  ctrlN;
  logic [2:0]  bankAddr;
  logic [13:0] addrBus;
  logic        wrapOut;

  int checks = 0;
  int fails = 0;

  // reference model state
  int         mIdx = 0;
  int         mGrade = 0;
  logic [3:0] mCtrl = 4'b1111;
  logic [2:0] mBank = 3'd0;
  logic [13:0] mAddr = 14'd0;

  always #2.5 clk = ~clk;

  ilv_cmd_gen u_ilv_cmd_gen (
    .clk(clk), .rstN(rstN), .enable(enable), .gradeSel(gradeSel),
    .cmdCode(cmdCode), .ctrlN(ctrlN), .bankAddr(bankAddr),
    .addrBus(addrBus), .wrapOut(wrapOut)
  );

  function automatic int gapOf(int gr, int b);
    bit edgeBank = (b == 3) || (b == 7);
    case (gr)
      0: return 0;
      1: return edgeBank ? 2 : 0;
      2: return edgeBank ? 2 : 1;
      default: return edgeBank ? 3 : 1;
    endcase
  endfunction

  function automatic int passLen(int gr);
    int n = 0;
    for (int b = 0; b < 8; b++) n += 2 + gapOf(gr, b);
    return n;
  endfunction

  // returns {cmd[1:0], bank[2:0]} for slot idx of a pass
  function automatic logic [4:0] slotOf(int gr, int idx);
    int p = 0;
    for (int b = 0; b < 8; b++) begin
      if (idx == p) return {2'd1, 3'(b)};
      if (idx == p + 1) return {2'd2, 3'(b)};
      if (idx > p + 1 && idx <= p + 1 + gapOf(gr, b)) return {2'd0, 3'(b)};
      p += 2 + gapOf(gr, b);
    end
    return 5'd0;
  endfunction

  function automatic string gradeTag(int gr);
    case (gr)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, compare after the edge
  task automatic step(input logic en, input logic [1:0] g);
    logic [4:0]  s;
    logic [1:0]  eCmd;
    logic [2:0]  eBank;
    logic [3:0]  eCtrl;
    logic [13:0] eAddr;
    logic        eWrap;
    string       tag;
    @(negedge clk);
    enable   = en;
    gradeSel = g;
    @(posedge clk);
    eWrap = 1'b0;
    if (en) begin
      if (mIdx == 0) mGrade = int'(g);
      s = slotOf(mGrade, mIdx);
      eCmd = s[4:3];
      eBank = s[2:0];
      eWrap = (mIdx == passLen(mGrade) - 1);
      mIdx = (mIdx + 1) % passLen(mGrade);
      tag = gradeTag(mGrade);
    end else begin
      eCmd = 2'd0;
      eBank = mBank;
      tag = "R11";
    end
    case (eCmd)
      2'd1: begin eCtrl = 4'b0011; eAddr = ROWB + 14'(eBank); end
      2'd2: begin eCtrl = 4'b0101; eAddr = COLAP; end
      default: begin eCtrl = {1'b1, mCtrl[2:0]}; eBank = mBank; eAddr = mAddr; end
    endcase
    mCtrl = eCtrl; mBank = eBank; mAddr = eAddr;
    #1;
    chk({tag, " cmd"}, 32'(cmdCode), 32'(eCmd));
    chk(eCmd == 2'd0 ? "R8 bank" : "R3 bank", 32'(bankAddr), 32'(eBank));
    chk(eCmd == 2'd0 ? "R8 ctrl" : "R2 ctrl", 32'(ctrlN), 32'(eCtrl));
    chk(eCmd == 2'd0 ? "R8 addr" : "R12 addr", 32'(addrBus), 32'(eAddr));
    chk("R9 wrap", 32'(wrapOut), 32'(eWrap));
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int desCnt;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 cmd", 32'(cmdCode), 0);
    chk("R1 ctrl", 32'(ctrlN), 32'hF);
    chk("R1 bank", 32'(bankAddr), 0);
    chk("R1 addr", 32'(addrBus), 0);
    chk("R1 wrap", 32'(wrapOut), 0);
    @(negedge clk);
    rstN = 1'b1;
    step(1'b0, 2'd0);
    chk("R1 idle cmd", 32'(cmdCode), 0);

    // full directed passes per grade, counting deselects
    for (int gr = 0; gr < 4; gr++) begin
      desCnt = 0;
      for (int i = 0; i < passLen(gr); i++) begin
        step(1'b1, 2'(gr));
        if (cmdCode == 2'd0) desCnt++;
      end
      chk({gradeTag(gr), " wrap at pass end"}, 32'(wrapOut), 1);
      chk({gradeTag(gr), " deselect count"}, 32'(desCnt), 32'(passLen(gr) - 16));
    end

    // R10: grade 3 pass with the select changed to 0 mid-pass
    for (int i = 0; i < 28; i++) step(1'b1, i < 5 ? 2'd3 : 2'd0);
    chk("R10 pass kept grade 3 length", 32'(wrapOut), 1);
    for (int i = 0; i < 16; i++) step(1'b1, 2'd0);
    chk("R10 next pass uses new grade", 32'(wrapOut), 1);

    // R11: pauses inside a grade 2 pass, including during a gap
    for (int i = 0; i < 26; i++) begin
      step(1'b1, 2'd2);
      if (i == 2 || i == 9) begin
        step(1'b0, 2'd1);
        step(1'b0, 2'd3);
        chk("R11 paused cmd", 32'(cmdCode), 0);
      end
    end
    chk("R11 resumed pass completes", 32'(wrapOut), 1);

    // random enable and grade
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] g;
      g = ($urandom % 8 == 0) ? 2'($urandom) : gradeSel;
      step(($urandom % 5) != 0, g);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule